// File: doc/BRIEF.md
# Saturating Pulse Accumulator with Snapshot Register

This block counts active-edge pulses in an 8-bit register. Each single-cycle pulse on the edge input adds one to the live count while counting is enabled. A mode input sets what happens at 0xFF. In wrap mode the count rolls over to zero. In saturate mode it stays at 0xFF, and that value then means 255 or more edges. Software can clear the count at any time, and the clear wins over an edge that arrives in the same cycle.

A snapshot register sits next to the counter. It lets software read a stable copy of the count while pulses keep arriving. The snapshot is armed by a buffer-enable input and by a latch-select input. A one-cycle strobe copies the live count into it only when both are set. While buffer-enable is low, the snapshot register is off and reads zero. Edge polarity selection, input synchronisation and interrupt generation are done elsewhere. The edge input is taken to be an already synchronised single-cycle pulse.

Top module: `pulse_tally`

## Requirements
- R1: After a synchronous active-low reset, the live count and the snapshot both read 0x00.
- R2: While enabled, each cycle with the edge input high raises the live count by one, visible on the next clock.
- R3: While the enable input is low, edge pulses are ignored and the live count keeps its value.
- R4: In wrap mode (sat_mode_i = 0), an edge at a count of 0xFF makes the count 0x00.
- R5: In saturate mode (sat_mode_i = 1), an edge at a count of 0xFF leaves the count at 0xFF.
- R6: A clear forces the count to 0x00 on the next clock, even when an enabled edge arrives in the same cycle.
- R7: When buf_en_i, latch_sel_i and latch_strobe_i are all high in one cycle, the snapshot shows that cycle's live count from the next clock on.
- R8: With buf_en_i high and latch_sel_i low, a strobe is ignored and the snapshot keeps its value.
- R9: While buf_en_i is low, the snapshot reads 0x00 from the next clock on and strobes have no effect.
- R10: A strobe in the same cycle as a counted edge or a clear captures the count as it was before that edge or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_i | input | 1 | Single-cycle pulse marking one active edge |
| enable_i | input | 1 | Counting enable |
| sat_mode_i | input | 1 | 0 = wrap at 0xFF, 1 = saturate at 0xFF |
| clear_i | input | 1 | Software clear of the live count |
| buf_en_i | input | 1 | Switches the snapshot register on |
| latch_sel_i | input | 1 | Lets the strobe take a snapshot |
| latch_strobe_i | input | 1 | One-cycle request to take a snapshot |
| count_o | output | 8 | Live count |
| held_o | output | 8 | Snapshot of the count |

## Verification
The bench drives the counter through the 0xFF boundary in both policies. A design with the policy reversed, or an off-by-one terminal value, would either stick at 0xFF in wrap mode or roll to 0x00 in saturate mode. It sends a clear together with an edge, so a design that gives the increment priority would show 0x01 instead of 0x00. It sends strobes together with edges and with clears, so a design that samples the next-state value would capture a count one too high or zero. It also sends strobes with latch-select low and with buffer-enable low, which catches a snapshot that ignores its arming inputs or is not zero while switched off.

// File: rtl/pulse_tally_pkg.sv
// Shared definitions for the pulse accumulator.
// Assumes: none; holds only constants and types.
package pulse_tally_pkg;

    localparam int TALLY_W = 8;

    typedef enum logic {
        POL_WRAP = 1'b0,
        POL_SAT  = 1'b1
    } ovf_policy_e;

endpackage

// File: rtl/tally_counter.sv
// Live edge counter with a selectable overflow policy at the all-ones value.
// Assumes: step_i is already qualified by the enable; clear_i wins over step_i.
module tally_counter
    import pulse_tally_pkg::*;
#(
    parameter int W = TALLY_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         clear_i,
    input  ovf_policy_e  policy_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         at_top;

    assign at_top = (cnt_q == TOP);

    // Next-count selection: clear first, then step with the overflow policy.
    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            if (at_top) begin
                cnt_d = (policy_i == POL_SAT) ? TOP : '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && !at_top) |=> (count_o == $past(count_o) + 1'b1));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(count_o));

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && at_top && policy_i == POL_WRAP) |=> (count_o == '0));

    a_r5_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && at_top && policy_i == POL_SAT) |=> (count_o == TOP));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == '0));

endmodule

// File: rtl/tally_holder.sv
// Snapshot register that copies the live count on an armed strobe.
// Assumes: live_i is the registered count, so a copy taken in the same cycle
// as an edge or a clear sees the value before that update.
module tally_holder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm_i,
    input  logic         sel_i,
    input  logic         strobe_i,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] held_o
);

    logic [W-1:0] held_q;
    logic         take;

    assign take = arm_i && sel_i && strobe_i;

    // Snapshot register: zero while off, copy on an armed strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (!arm_i) begin
            held_q <= '0;
        end else if (take) begin
            held_q <= live_i;
        end
    end

    assign held_o = held_q;

    a_r7_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && sel_i && strobe_i) |=> (held_o == $past(live_i)));

    a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !sel_i) |=> $stable(held_o));

    a_r9_off: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (held_o == '0));

endmodule

// File: rtl/pulse_tally.sv
// Top of the pulse accumulator: qualifies edges with the enable and joins the
// live counter to its snapshot register.
// Assumes: edge_i is a synchronised one-cycle pulse per active edge.
module pulse_tally
    import pulse_tally_pkg::*;
#(
    parameter int W = TALLY_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_i,
    input  logic         enable_i,
    input  logic         sat_mode_i,
    input  logic         clear_i,
    input  logic         buf_en_i,
    input  logic         latch_sel_i,
    input  logic         latch_strobe_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] held_o
);

    logic         step;
    ovf_policy_e  policy;
    logic [W-1:0] live;

    assign step   = edge_i && enable_i;
    assign policy = sat_mode_i ? POL_SAT : POL_WRAP;

    tally_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .clear_i  (clear_i),
        .policy_i (policy),
        .count_o  (live)
    );

    tally_holder #(.W(W)) u_holder (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (buf_en_i),
        .sel_i    (latch_sel_i),
        .strobe_i (latch_strobe_i),
        .live_i   (live),
        .held_o   (held_o)
    );

    assign count_o = live;

    a_r10_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en_i && latch_sel_i && latch_strobe_i && (step || clear_i))
            |=> (held_o == $past(count_o)));

endmodule

// File: tb/test_pulse_tally.sv
module test_pulse_tally;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       edge_i = 1'b0, enable_i = 1'b0, sat_mode_i = 1'b0, clear_i = 1'b0;
    logic       buf_en_i = 1'b0, latch_sel_i = 1'b0, latch_strobe_i = 1'b0;
    logic [7:0] count_o, held_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] q_cnt[$];
    logic [7:0] q_hld[$];
    string      q_tag[$];

    logic [7:0] m_cnt = 8'h00;
    logic [7:0] m_hld = 8'h00;

    always #10 clk = ~clk;

    pulse_tally i_pulse_tally (
        .clk(clk), .rst_n(rst_n), .edge_i(edge_i), .enable_i(enable_i),
        .sat_mode_i(sat_mode_i), .clear_i(clear_i), .buf_en_i(buf_en_i),
        .latch_sel_i(latch_sel_i), .latch_strobe_i(latch_strobe_i),
        .count_o(count_o), .held_o(held_o)
    );

    task automatic step(input logic e, input logic en, input logic sat,
                        input logic clr, input logic be, input logic ls,
                        input logic st, input string tag);
        logic [7:0] nc;
        logic [7:0] nh;
        @(negedge clk);
        edge_i = e; enable_i = en; sat_mode_i = sat; clear_i = clr;
        buf_en_i = be; latch_sel_i = ls; latch_strobe_i = st;
        nh = !be ? 8'h00 : ((ls && st) ? m_cnt : m_hld);
        if (clr)            nc = 8'h00;
        else if (e && en)   nc = (m_cnt == 8'hFF) ? (sat ? 8'hFF : 8'h00) : m_cnt + 8'h01;
        else                nc = m_cnt;
        m_cnt = nc;
        m_hld = nh;
        q_cnt.push_back(nc);
        q_hld.push_back(nh);
        q_tag.push_back(tag);
    endtask

    // Monitor: compares each expected item once the edge after it has settled.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_cnt.size() > 0) begin
                logic [7:0] ec;
                logic [7:0] eh;
                string t;
                ec = q_cnt.pop_front();
                eh = q_hld.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (count_o !== ec || held_o !== eh) begin
                    errors++;
                    $display("FAIL %s count=%02h held=%02h expected count=%02h held=%02h",
                             t, count_o, held_o, ec, eh);
                end
            end
        end
    end

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog run hung actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (count_o !== 8'h00 || held_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 count=%02h held=%02h expected count=00 held=00", count_o, held_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 1, 1, 0, "R2");
        step(0, 1, 0, 0, 1, 1, 0, "R2");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, 1, 0, "R3");
        step(0, 1, 0, 0, 1, 1, 1, "R7");
        step(1, 1, 0, 0, 1, 0, 1, "R8");
        step(1, 1, 0, 0, 1, 0, 0, "R8");
        step(1, 1, 0, 0, 1, 1, 1, "R10");
        step(0, 1, 0, 0, 0, 1, 1, "R9");
        step(1, 1, 0, 0, 0, 1, 1, "R9");
        step(0, 1, 0, 0, 1, 1, 1, "R7");
        step(1, 1, 0, 1, 1, 1, 1, "R6");
        step(1, 1, 0, 0, 1, 1, 1, "R10");
        step(0, 1, 0, 1, 1, 1, 0, "R6");
        for (int i = 0; i < 255; i++) step(1, 1, 0, 0, 1, 0, 0, "R2");
        step(0, 1, 0, 0, 1, 1, 1, "R7");
        step(1, 1, 0, 0, 1, 0, 0, "R4");
        step(1, 1, 0, 0, 1, 0, 0, "R4");
        for (int i = 0; i < 254; i++) step(1, 1, 1, 0, 1, 0, 0, "R2");
        step(1, 1, 1, 0, 1, 0, 0, "R5");
        step(1, 1, 1, 0, 1, 0, 0, "R5");
        step(1, 1, 1, 0, 1, 1, 1, "R10");
        step(1, 1, 1, 1, 1, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 0, 0, "R6");

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule